// File: doc/BRIEF.md
# Bidirectional Parity Transceiver

This block moves one data byte between two buses. The A side is a plain 8-bit bus. The B side is 9 bits wide: the same 8 data bits plus a parity bit. Each side has separate input, output and drive-enable signals, so the block can sit between two tri-state pad rings or two on-chip buses.

When the A-to-B direction is selected, the byte on A appears unchanged on B, together with a freshly computed odd-parity bit. When the B-to-A direction is selected, the byte on B appears unchanged on A. On every rising clock edge in that direction, the nine received B bits are tested. If they hold an even number of ones, an active-low error flag is set. The flag is sticky and stays low until a synchronous clear or the asynchronous reset releases it.

Two active-low direction enables choose the mode. Only A-to-B enabled, or only B-to-A enabled, selects that direction. Both released, or both asserted together, isolates the buses: no side is driven and the error flag holds its value. A combinational parity output always shows the odd-parity bit of the byte currently being passed.

Top module: `parity_xcvr`

## Requirements
- R1: With `drvBN`=0 and `drvAN`=1 (A-to-B), `bOut` equals `aIn`, `bOutEn`=1 and `aOutEn`=0, with no clock delay.
- R2: In A-to-B mode, `bParOut` is chosen so that `bOut` and `bParOut` together hold an odd number of ones.
- R3: With `drvAN`=0 and `drvBN`=1 (B-to-A), `aOut` equals `bIn`, `aOutEn`=1 and `bOutEn`=0, with no clock delay.
- R4: With both enables at 1, both drive enables are 0 and `aOut`, `bOut` and `bParOut` read 0.
- R5: With both enables at 0, both drive enables are 0, the data outputs read 0, and `errN` keeps its value across clock edges.
- R6: At a rising edge in B-to-A mode, an even count of ones in {`bIn`,`bParIn`} drives `errN` to 0. An odd count leaves `errN` unchanged.
- R7: Once low, `errN` stays low until a rising edge with `errClr`=1, which sets it to 1 in any mode. A clear takes priority over a simultaneous error.
- R8: At rising edges outside B-to-A mode, `errN` does not change, whatever the B inputs hold.
- R9: `rstN`=0 sets `errN` to 1 at once, without waiting for a clock edge.
- R10: `parOut` is the odd-parity bit of `bIn` in B-to-A mode, and of `aIn` in every other mode, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the error register samples on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| drvAN | input | 1 | Active-low enable for the B-to-A direction |
| drvBN | input | 1 | Active-low enable for the A-to-B direction |
| aIn | input | DATA_W | Data received from the A bus |
| aOut | output | DATA_W | Data to drive onto the A bus |
| aOutEn | output | 1 | Drive enable for the A bus |
| bIn | input | DATA_W | Data received from the B bus |
| bParIn | input | 1 | Parity bit received from the B bus |
| bOut | output | DATA_W | Data to drive onto the B bus |
| bParOut | output | 1 | Generated parity bit to drive onto the B bus |
| bOutEn | output | 1 | Drive enable for the B bus (data and parity) |
| errClr | input | 1 | Synchronous clear of the error flag |
| errN | output | 1 | Registered, sticky, active-low parity error flag |
| parOut | output | 1 | Odd-parity bit of the byte currently passed |

## Verification
The data outputs, the drive enables and both parity outputs are combinational. Each test applies its stimulus just after a falling edge and samples these outputs 2 ns later, before any rising edge.

The error flag passes through one register. It is due one rising edge after the stimulus, so the bench samples it at the following falling edge. The hold and clear cases check the flag at that same point.

The asynchronous reset is checked 1 ns after `rstN` falls in the middle of a cycle, before any clock edge can act.

// File: rtl/parity_xcvr_pkg.sv
package parity_xcvr_pkg;

  typedef enum logic [1:0] {
    MODE_ISOLATE = 2'd0,
    MODE_A2B     = 2'd1,
    MODE_B2A     = 2'd2
  } xfer_mode_e;

  // strobes handed from control to datapath
  typedef struct packed {
    logic driveB;     // pass A onto B with generated parity
    logic driveA;     // pass B onto A
    logic useBWord;   // parity monitor looks at the B word
    logic errSample;  // error register may capture a check result
    logic errClear;   // error register returns to idle
  } xcvr_ctl_t;

endpackage

// File: rtl/parity_xcvr_ctrl.sv
module parity_xcvr_ctrl
  import parity_xcvr_pkg::*;
(
  input  logic       drvAN,
  input  logic       drvBN,
  input  logic       errClr,
  output xcvr_ctl_t  ctl
);

  xfer_mode_e mode;

  // exactly one enable low selects a direction; both low or both high isolate
  always_comb begin
    unique case ({drvAN, drvBN})
      2'b10:   mode = MODE_A2B;
      2'b01:   mode = MODE_B2A;
      default: mode = MODE_ISOLATE;
    endcase
  end

  always_comb begin
    ctl.driveB    = (mode == MODE_A2B);
    ctl.driveA    = (mode == MODE_B2A);
    ctl.useBWord  = (mode == MODE_B2A);
    ctl.errSample = (mode == MODE_B2A);
    ctl.errClear  = errClr;
  end

endmodule

// File: rtl/parity_xcvr_dp.sv
module parity_xcvr_dp
  import parity_xcvr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  xcvr_ctl_t         ctl,
  input  logic [DATA_W-1:0] aIn,
  input  logic [DATA_W-1:0] bIn,
  input  logic              bParIn,
  output logic [DATA_W-1:0] aOut,
  output logic              aOutEn,
  output logic [DATA_W-1:0] bOut,
  output logic              bParOut,
  output logic              bOutEn,
  output logic              parOut,
  output logic              errN
);

  localparam int CHAIN_LEN = DATA_W + 1;

  // XOR chains: A and B seeded with 1 give odd-parity bits; the check chain
  // is seeded with the received parity bit, so its end is 1 when the 9 bits are odd
  logic [CHAIN_LEN-1:0] aChain;
  logic [CHAIN_LEN-1:0] bChain;
  logic [CHAIN_LEN-1:0] chkChain;

  assign aChain[0]   = 1'b1;
  assign bChain[0]   = 1'b1;
  assign chkChain[0] = bParIn;

  for (genvar i = 0; i < DATA_W; i++) begin : g_par
    assign aChain[i+1]   = aChain[i]   ^ aIn[i];
    assign bChain[i+1]   = bChain[i]   ^ bIn[i];
    assign chkChain[i+1] = chkChain[i] ^ bIn[i];
  end

  logic aOddBit;
  logic bOddBit;
  logic rxEven;

  assign aOddBit = aChain[DATA_W];
  assign bOddBit = bChain[DATA_W];
  assign rxEven  = ~chkChain[DATA_W];

  always_comb begin
    bOutEn  = ctl.driveB;
    aOutEn  = ctl.driveA;
    bOut    = ctl.driveB ? aIn : '0;
    bParOut = ctl.driveB ? aOddBit : 1'b0;
    aOut    = ctl.driveA ? bIn : '0;
    parOut  = ctl.useBWord ? bOddBit : aOddBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errN <= 1'b1;
    end else if (ctl.errClear) begin
      errN <= 1'b1;
    end else if (ctl.errSample && rxEven) begin
      errN <= 1'b0;
    end
  end

endmodule

// File: rtl/parity_xcvr.sv
module parity_xcvr
  import parity_xcvr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              drvAN,
  input  logic              drvBN,
  input  logic [DATA_W-1:0] aIn,
  output logic [DATA_W-1:0] aOut,
  output logic              aOutEn,
  input  logic [DATA_W-1:0] bIn,
  input  logic              bParIn,
  output logic [DATA_W-1:0] bOut,
  output logic              bParOut,
  output logic              bOutEn,
  input  logic              errClr,
  output logic              errN,
  output logic              parOut
);

  xcvr_ctl_t ctl;

  parity_xcvr_ctrl ctrl_i (
    .drvAN  (drvAN),
    .drvBN  (drvBN),
    .errClr (errClr),
    .ctl    (ctl)
  );

  parity_xcvr_dp #(.DATA_W(DATA_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .aIn     (aIn),
    .bIn     (bIn),
    .bParIn  (bParIn),
    .aOut    (aOut),
    .aOutEn  (aOutEn),
    .bOut    (bOut),
    .bParOut (bParOut),
    .bOutEn  (bOutEn),
    .parOut  (parOut),
    .errN    (errN)
  );

endmodule

// File: rtl/parity_xcvr_chk.sv
module parity_xcvr_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              drvAN,
  input logic              drvBN,
  input logic [DATA_W-1:0] aIn,
  input logic [DATA_W-1:0] aOut,
  input logic              aOutEn,
  input logic [DATA_W-1:0] bIn,
  input logic              bParIn,
  input logic [DATA_W-1:0] bOut,
  input logic              bParOut,
  input logic              bOutEn,
  input logic              errClr,
  input logic              errN,
  input logic              parOut
);

  logic b2a;
  assign b2a = !drvAN && drvBN;

  // R1
  a2b_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (drvAN && !drvBN) |-> (bOutEn && !aOutEn && bOut == aIn));

  // R2
  b_odd_chk: assert property (@(posedge clk) disable iff (!rstN)
    bOutEn |-> ($countones({bOut, bParOut}) % 2 == 1));

  // R3
  b2a_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    b2a |-> (aOutEn && !bOutEn && aOut == bIn));

  // R4
  no_dual_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({aOutEn, bOutEn}));

  // R6
  err_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (b2a && !errClr && ($countones({bIn, bParIn}) % 2 == 0)) |=> !errN);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!errN && !errClr) |=> !errN);

  // R7
  err_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    errClr |=> errN);

  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!b2a && !errClr) |=> $stable(errN));

endmodule

bind parity_xcvr parity_xcvr_chk #(.DATA_W(DATA_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .drvAN   (drvAN),
  .drvBN   (drvBN),
  .aIn     (aIn),
  .aOut    (aOut),
  .aOutEn  (aOutEn),
  .bIn     (bIn),
  .bParIn  (bParIn),
  .bOut    (bOut),
  .bParOut (bParOut),
  .bOutEn  (bOutEn),
  .errClr  (errClr),
  .errN    (errN),
  .parOut  (parOut)
);

// File: tb/parity_xcvr_tb_top.sv
`timescale 1ns/1ps
module parity_xcvr_tb_top;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN;
  logic         drvAN, drvBN;
  logic [W-1:0] aIn, bIn;
  logic         bParIn, errClr;
  logic [W-1:0] aOut, bOut;
  logic         aOutEn, bOutEn, bParOut, errN, parOut;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  parity_xcvr #(.DATA_W(W)) dut_i (
    .clk(clk), .rstN(rstN), .drvAN(drvAN), .drvBN(drvBN),
    .aIn(aIn), .aOut(aOut), .aOutEn(aOutEn),
    .bIn(bIn), .bParIn(bParIn), .bOut(bOut), .bParOut(bParOut), .bOutEn(bOutEn),
    .errClr(errClr), .errN(errN), .parOut(parOut)
  );

  function automatic logic oddBit(input logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) n += v[i];
    return (n % 2 == 0);
  endfunction

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setMode(input logic an, input logic bn);
    drvAN = an;
    drvBN = bn;
  endtask

  task automatic testReset();
    chk("R9 reset errN", {7'd0, errN}, 8'd1);
    chk("R4 reset aOutEn", {7'd0, aOutEn}, 8'd0);
  endtask

  task automatic testAtoB();
    logic [W-1:0] pats[5] = '{8'h00, 8'hFF, 8'hA5, 8'h01, 8'h80};
    setMode(1'b1, 1'b0);
    foreach (pats[k]) begin
      aIn = pats[k];
      bIn = ~pats[k];
      #2;
      chk("R1 bOut", bOut, pats[k]);
      chk("R1 enables", {6'd0, bOutEn, aOutEn}, 8'b10);
      chk("R2 bParOut", {7'd0, bParOut}, {7'd0, oddBit(pats[k])});
      chk("R10 parOut A", {7'd0, parOut}, {7'd0, oddBit(pats[k])});
      @(negedge clk);
    end
  endtask

  task automatic testBtoA();
    logic [W-1:0] pats[4] = '{8'h00, 8'h3C, 8'h7F, 8'hC1};
    setMode(1'b0, 1'b1);
    foreach (pats[k]) begin
      bIn    = pats[k];
      bParIn = oddBit(pats[k]);
      aIn    = 8'h5A;
      #2;
      chk("R3 aOut", aOut, pats[k]);
      chk("R3 enables", {6'd0, bOutEn, aOutEn}, 8'b01);
      chk("R10 parOut B", {7'd0, parOut}, {7'd0, oddBit(pats[k])});
      step();
      chk("R6 good parity keeps errN", {7'd0, errN}, 8'd1);
    end
  endtask

  task automatic testIsolate();
    setMode(1'b1, 1'b1);
    aIn = 8'h96; bIn = 8'h03; bParIn = 1'b0;
    #2;
    chk("R4 enables off", {6'd0, bOutEn, aOutEn}, 8'b00);
    chk("R4 aOut zero", aOut, 8'h00);
    chk("R4 bOut zero", {bOut[W-2:0], bParOut}, 8'h00);
    chk("R10 parOut isolate", {7'd0, parOut}, {7'd0, oddBit(8'h96)});
    step();
    chk("R8 isolate ignores bad B", {7'd0, errN}, 8'd1);
    setMode(1'b1, 1'b0);
    step();
    chk("R8 A2B ignores bad B", {7'd0, errN}, 8'd1);
    setMode(1'b0, 1'b0);
    #2;
    chk("R5 both low enables off", {6'd0, bOutEn, aOutEn}, 8'b00);
    chk("R5 both low aOut zero", aOut, 8'h00);
    step();
    chk("R5 both low ignores bad B", {7'd0, errN}, 8'd1);
  endtask

  task automatic testErrSticky();
    setMode(1'b0, 1'b1);
    bIn = 8'h03; bParIn = 1'b0;
    step();
    chk("R6 even ones sets errN", {7'd0, errN}, 8'd0);
    bIn = 8'h07; bParIn = 1'b0;
    step();
    chk("R7 sticky after good word", {7'd0, errN}, 8'd0);
    setMode(1'b0, 1'b0);
    step();
    chk("R5 both low holds set errN", {7'd0, errN}, 8'd0);
    setMode(1'b1, 1'b1);
    errClr = 1'b1;
    step();
    errClr = 1'b0;
    chk("R7 clear in isolate", {7'd0, errN}, 8'd1);
  endtask

  task automatic testClrPriority();
    setMode(1'b0, 1'b1);
    bIn = 8'hFF; bParIn = 1'b1;
    step();
    chk("R6 nine ones is odd, no error", {7'd0, errN}, 8'd1);
    bParIn = 1'b0;
    errClr = 1'b1;
    step();
    chk("R7 clear beats set", {7'd0, errN}, 8'd1);
    errClr = 1'b0;
    step();
    chk("R6 set after clear released", {7'd0, errN}, 8'd0);
  endtask

  task automatic testAsyncReset();
    #5 rstN = 1'b0;
    #1;
    chk("R9 async reset", {7'd0, errN}, 8'd1);
    @(negedge clk);
    rstN = 1'b1;
    bParIn = 1'b1;
    step();
  endtask

  initial begin
    rstN = 1'b0; drvAN = 1'b1; drvBN = 1'b1;
    aIn = '0; bIn = '0; bParIn = 1'b0; errClr = 1'b0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testAtoB();
    testBtoA();
    testIsolate();
    testErrSticky();
    testClrPriority();
    testAsyncReset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule